// File: doc/BRIEF.md
# Frequency Synthesizer Serial Loader

This block loads a set of divider and range parameters into an external frequency synthesizer over a three-line serial link: a data line, a serial clock and a select line that frames the load. A one-cycle start pulse captures the five parameter fields. The block then opens the load with a select pulse and clocks out a 24-bit word, one bit per serial clock period. When the word is complete it stops driving all three lines.

The word carries the fields in a fixed order, each least significant bit first. A constant 5-bit trailer closes it. Every serial clock phase lasts `PHASE_CYC` system clocks. The whole transfer therefore lasts 50 phases: one select phase, 24 low/high bit pairs and one closing low phase. A typical load is N=120, M=100, V=1, X=1, R=2, which programs 1.5 MHz. Working out the parameters from a target frequency is left to whatever drives the block.

Top module: `synth_loader`

## Requirements
- R1: After reset and while idle, busy_o, done_o, oe_o, sel_o, sclk_o and sdata_o are all low.
- R2: An accepted start raises busy_o and oe_o. For the first PHASE_CYC cycles, sel_o is high while sclk_o and sdata_o are low. sel_o then stays low for the rest of the transfer.
- R3: Exactly 24 rising edges of sclk_o occur. The bit shown on sdata_o at rising edge k is bit k of the word. The word is {5'h17, R[1:0], X[1:0], V, M[6:0], N[6:0]}: N in bits 0-6, M in 7-13, V in 14, X in 15-16, R in 17-18 and the trailer 0x17 in 19-23.
- R4: Each bit is placed on sdata_o while sclk_o is low. sclk_o then stays high for exactly PHASE_CYC cycles, and sdata_o does not change during that time.
- R5: After the last high phase, sclk_o stays low for one further phase. busy_o and oe_o then fall together, having been high for exactly 50*PHASE_CYC cycles. done_o is high for exactly the first cycle after that.
- R6: A start pulse while busy_o is high is ignored. The word in progress and the transfer length are unchanged.
- R7: The parameter fields are captured with the accepted start. Changing the parameter inputs during a transfer does not change the word that is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| n_i | input | 7 | Feedback divider field |
| m_i | input | 7 | Reference divider field |
| v_i | input | 1 | VCO prescale field |
| x_i | input | 2 | Output divider X field |
| r_i | input | 2 | Output divider R field |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse after the lines are released |
| sdata_o | output | 1 | Serial data |
| sclk_o | output | 1 | Serial clock |
| sel_o | output | 1 | Synthesizer select pulse |
| oe_o | output | 1 | Output enable for the three serial lines |

## Verification
The hardest case to reach from the ports is a second start that arrives halfway through a word, together with new parameter values. If either one were taken, the link would show only a subtly wrong word or a longer transfer. The bench runs a transfer and, partway through the shifting, pulses start and drives a different pattern on every field. It then checks the captured word against the first pattern and checks the busy time against 50 phases. A walking-one sweep over all 19 parameter bits also shows any field misplaced by a single bit.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;
  localparam int N_W = 7;
  localparam int M_W = 7;
  localparam int V_W = 1;
  localparam int X_W = 2;
  localparam int R_W = 2;
  localparam int TRL_W = 5;
  localparam logic [TRL_W-1:0] TRAILER = 5'h17;
  localparam int WORD_W = N_W + M_W + V_W + X_W + R_W + TRL_W;
  localparam int BIT_CNT_W = $clog2(WORD_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_LO,
    ST_HI,
    ST_TAIL
  } ld_state_e;

  function automatic logic [WORD_W-1:0] pack_word(
    input logic [N_W-1:0] n, input logic [M_W-1:0] m, input logic [V_W-1:0] v,
    input logic [X_W-1:0] x, input logic [R_W-1:0] r);
    return {TRAILER, r, x, v, m, n};
  endfunction
endpackage

// File: rtl/phase_timer.sv
module phase_timer #(
  parameter int PHASE_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = !clr_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i || cnt_q == LAST) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
  parameter int WORD_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              shift_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sh_q;

  assign bit_o = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[WORD_W-1:1]};
  end
endmodule

// File: rtl/synth_loader.sv
module synth_loader
  import synth_loader_pkg::*;
#(
  parameter int PHASE_CYC = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] n_i,
  input  logic [M_W-1:0] m_i,
  input  logic [V_W-1:0] v_i,
  input  logic [X_W-1:0] x_i,
  input  logic [R_W-1:0] r_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           sdata_o,
  output logic           sclk_o,
  output logic           sel_o,
  output logic           oe_o
);
  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(WORD_W - 1);

  ld_state_e            state_q, state_d;
  logic [BIT_CNT_W-1:0] bit_q;
  logic                 tick, load, shift, cur_bit, done_q;

  assign load  = (state_q == ST_IDLE) && start_i;
  assign shift = (state_q == ST_HI) && tick && (bit_q != LAST_BIT);

  phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_IDLE),
    .tick_o (tick)
  );

  word_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .word_i  (pack_word(n_i, m_i, v_i, x_i, r_i)),
    .shift_i (shift),
    .bit_o   (cur_bit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_SEL;
      ST_SEL:  if (tick)    state_d = ST_LO;
      ST_LO:   if (tick)    state_d = ST_HI;
      ST_HI:   if (tick)    state_d = (bit_q == LAST_BIT) ? ST_TAIL : ST_LO;
      ST_TAIL: if (tick)    state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_TAIL) && tick;
      if (load)       bit_q <= '0;
      else if (shift) bit_q <= bit_q + 1'b1;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign oe_o    = busy_o;
  assign done_o  = done_q;
  assign sel_o   = (state_q == ST_SEL);
  assign sclk_o  = (state_q == ST_HI);
  assign sdata_o = ((state_q == ST_LO) || (state_q == ST_HI)) && cur_bit;

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !(sclk_o || sel_o || sdata_o));
  // R2
  sel_sclk_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_o && sclk_o));
  // R4
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> (!sclk_o || $stable(sdata_o)));
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R6
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !sel_o) |=> !sel_o);
  // R3
  bit_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= LAST_BIT);
endmodule

// File: tb/tb_synth_loader.sv
module tb_synth_loader;
  localparam int P = 3;
  localparam int TOTAL = 50 * P;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [6:0] n_i = '0, m_i = '0;
  logic v_i = 1'b0;
  logic [1:0] x_i = '0, r_i = '0;
  logic busy_o, done_o, sdata_o, sclk_o, sel_o, oe_o;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  synth_loader #(.PHASE_CYC(P)) dut (
    .clk_i, .rst_ni, .start_i, .n_i, .m_i, .v_i, .x_i, .r_i,
    .busy_o, .done_o, .sdata_o, .sclk_o, .sel_o, .oe_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic run_word(input logic [6:0] n, input logic [6:0] m, input logic v,
                          input logic [1:0] x, input logic [1:0] r, input bit disturb);
    logic [23:0] exp = {5'h17, r, x, v, m, n};
    logic [23:0] got = '0;
    int rises = 0, busy_len = 0, sel_len = 0, hi_len = 0, t = 0;
    bit sel_late = 0, bad_hold = 0, bad_hi = 0, bad_oe = 0, bad_pre = 0;
    bit prev_sclk = 0, prev_sdata = 0, seen_done = 0;
    @(negedge clk_i);
    n_i = n; m_i = m; v_i = v; x_i = x; r_i = r; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!seen_done && t < 4 * TOTAL) begin
      if (disturb && t == 40) begin
        start_i = 1'b1; n_i = ~n; m_i = ~m; v_i = ~v; x_i = ~x; r_i = ~r;
      end else start_i = 1'b0;
      if (done_o) begin
        seen_done = 1;
        // R5 lines released with done
        chk(!busy_o && !oe_o && !sclk_o && !sel_o && !sdata_o, "R5", "release",
            {busy_o, oe_o, sclk_o, sel_o, sdata_o}, 0);
      end else begin
        if (busy_o) busy_len++;
        if (oe_o != busy_o) bad_oe = 1;
        if (sel_o) begin
          sel_len++;
          if (t >= P) sel_late = 1;
          if (sclk_o || sdata_o) bad_pre = 1;
        end
        if (sclk_o) begin
          hi_len++;
          if (!prev_sclk) begin
            if (rises < 24) got[rises] = sdata_o;
            rises++;
          end else if (sdata_o != prev_sdata) bad_hold = 1;
        end else if (prev_sclk) begin
          if (hi_len != P) bad_hi = 1;
          hi_len = 0;
        end
        prev_sclk = sclk_o; prev_sdata = sdata_o;
      end
      t++;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    chk(seen_done, "R5", "done seen", seen_done, 1);
    chk(!done_o, "R5", "done width", done_o, 0);
    chk(busy_len == TOTAL, disturb ? "R6" : "R5", "busy length", busy_len, TOTAL);
    chk(sel_len == P && !sel_late && !bad_pre, "R2", "select phase", sel_len, P);
    chk(!bad_oe, "R2", "oe tracks busy", bad_oe, 0);
    chk(rises == 24, "R3", "rising edges", rises, 24);
    chk(got == exp, disturb ? "R7" : "R3", "word", got, exp);
    chk(!bad_hold && !bad_hi, "R4", "bit timing", {bad_hold, bad_hi}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk({busy_o, done_o, oe_o, sel_o, sclk_o, sdata_o} == 0, "R1", "reset outputs",
        {busy_o, done_o, oe_o, sel_o, sclk_o, sdata_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, oe_o, sel_o, sclk_o, sdata_o} == 0, "R1", "idle outputs",
        {busy_o, done_o, oe_o, sel_o, sclk_o, sdata_o}, 0);
    run_word(7'd120, 7'd100, 1'b1, 2'd1, 2'd2, 0);
    run_word('0, '0, 1'b0, '0, '0, 0);
    run_word('1, '1, 1'b1, '1, '1, 0);
    for (int b = 0; b < 19; b++) begin
      logic [18:0] w = 19'(1) << b;
      run_word(w[6:0], w[13:7], w[14], w[16:15], w[18:17], 0);
    end
    // R6 R7 start and new fields mid-transfer
    run_word(7'h35, 7'h4a, 1'b0, 2'd3, 2'd1, 1);
    repeat (5) @(negedge clk_i);
    chk(!busy_o && !oe_o, "R6", "still idle after ignored start", busy_o, 0);
    summary();
  end
endmodule